// File: doc/BRIEF.md
# Segment Descriptor Loader

This block loads one segment register of a protected-mode processor core. A request carries a 16-bit selector, the class of the segment being loaded (data, code or stack), the current privilege level, the protection-enable and virtual-8086 flags, and the base and limit of both descriptor tables. When protection is off or the core runs in virtual-8086 mode, the block only records the selector and derives the base from it. Otherwise it bounds-checks the selector against the chosen table. It then fetches the 8-byte descriptor over a narrow memory read port and judges it against the rules of the requested segment class.

A load that passes refreshes the hidden descriptor cache shown on the `cache_*` outputs. A passing code load also reports a new privilege level. A load that fails leaves the cache untouched and raises a one-cycle fault strobe that carries a fault class and an error code. Gate descriptors are not followed: a system descriptor is simply refused.

Top module: `seg_loader`

## Requirements
- R1: With `prot_en` low or `v86` high, an accepted request raises `done` on the next cycle and issues no memory read. `cache_sel` becomes the selector and `cache_base` becomes the selector shifted left by 4. Every other cache field keeps its value.
- R2: Selector bit 2 picks the local table (1) or the global table (0). The descriptor address is the table base plus the selector with its low three bits cleared. The descriptor is read as two 32-bit words: the low half at that address first, then the high half at address+4. The read request is held with a stable address until `mem_rd_valid`.
- R3: If the selector with its low three bits cleared exceeds the chosen table's limit, the load faults with class general-protection and error code equal to the selector, and issues no memory read.
- R4: A stack load faults with general protection in four cases: a null selector (bits 15:3 zero, error code 0); a system descriptor (bit 44 clear); a descriptor that is executable (bit 43) or not writable (bit 41); or a requested privilege (selector bits 1:0) that differs from the current privilege or from the descriptor privilege (bits 46:45). The error code is the selector except for the null case. A stack load of a present-bit-clear (bit 47) descriptor that passes those checks raises a stack fault.
- R5: A code load faults with general protection, error code 0, on a null selector. It also faults with general protection, error code the selector, on a system descriptor. Otherwise a clear present bit raises a not-present fault, and this is checked before the executable bit. A non-executable descriptor then faults with general protection.
- R6: For a conforming code descriptor (bit 42 set), a descriptor privilege above the current privilege faults with general protection. For a non-conforming one, the load faults with general protection when the requested privilege is above the current privilege or when the current privilege differs from the descriptor privilege.
- R7: Only a passing code load pulses `cpl_wr` together with `done`, with `cpl_new` equal to the selector's requested privilege.
- R8: A data load with a null selector passes without a memory read. It leaves a cache holding the selector, its requested privilege and zero in every descriptor field.
- R9: A non-null data load faults with general protection on a system descriptor, or when the requested or current privilege is above the descriptor privilege. Otherwise a clear present bit raises a not-present fault.
- R10: A passing fetched load caches the following. The base is bits 63:56, 39:16. The limit is bits 51:48, 15:0. The type field {executable, conforming, writable, accessed} is bits 43:40. The system-or-user bit is bit 44, the privilege is bits 46:45, the present bit is bit 47 and the default size is bit 54.
- R11: When the granularity bit (bit 55) is set, the cached limit is the 20-bit limit shifted left by 12.
- R12: `flt_valid` lasts exactly one cycle and never coincides with `done`. Fault class encoding is 1 general protection, 2 not present, 3 stack. The cache keeps its value on every fault.
- R13: A request arriving while `busy` is high is ignored, and the load in progress completes with its own selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_req | input | 1 | Load request, taken when not busy |
| ld_sel | input | 16 | Selector to load |
| ld_class | input | 2 | Target class: 0 data, 1 code, 2 stack |
| cur_cpl | input | 2 | Current privilege level |
| prot_en | input | 1 | Protection enabled |
| v86 | input | 1 | Virtual-8086 mode |
| gdt_base | input | 32 | Global table base address |
| gdt_limit | input | 16 | Global table limit |
| ldt_base | input | 32 | Local table base address |
| ldt_limit | input | 32 | Local table limit |
| mem_rd_req | output | 1 | Descriptor word read request |
| mem_rd_addr | output | 32 | Read byte address |
| mem_rd_valid | input | 1 | Read data valid; accepts the request |
| mem_rd_data | input | 32 | Read data |
| busy | output | 1 | Descriptor fetch or judgement in progress |
| done | output | 1 | One-cycle pulse: load passed |
| flt_valid | output | 1 | One-cycle pulse: load faulted |
| flt_class | output | 2 | Fault class |
| flt_code | output | 16 | Fault error code |
| cpl_wr | output | 1 | New privilege level valid |
| cpl_new | output | 2 | New privilege level |
| cache_sel | output | 16 | Cached selector |
| cache_base | output | 32 | Cached base |
| cache_limit | output | 32 | Cached limit |
| cache_rpl | output | 2 | Cached requested privilege |
| cache_dpl | output | 2 | Cached descriptor privilege |
| cache_present | output | 1 | Cached present bit |
| cache_user | output | 1 | Cached code/data (not system) bit |
| cache_type | output | 4 | Cached type field |
| cache_big | output | 1 | Cached default size bit |

## Verification
The hardest case to reach from the ports is a second request landing while a fetch is stalled. Ignoring that request is only visible if the fetch lasts several cycles. The bench memory model therefore takes a programmable latency, and a long one is set so that a real-mode request can be slipped in mid-fetch. Its selector must never reach the cache. A second hard area is the ordering of checks within one class. Descriptors are built that break two rules at once, such as non-executable and not present for a code load. Each such descriptor shows which fault wins.

// File: rtl/seg_pkg.sv
`timescale 1ns/1ps
// seg_pkg: shared types for the segment loader.
// Assumes the standard 8-byte descriptor bit layout.
package seg_pkg;

    typedef enum logic [1:0] {
        CLS_DATA  = 2'd0,
        CLS_CODE  = 2'd1,
        CLS_STACK = 2'd2
    } seg_class_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_GP    = 2'd1,
        FLT_NP    = 2'd2,
        FLT_STACK = 2'd3
    } flt_e;

    typedef enum logic [1:0] {
        PATH_REAL  = 2'd0,
        PATH_FAULT = 2'd1,
        PATH_NULL  = 2'd2,
        PATH_FETCH = 2'd3
    } path_e;

    typedef struct packed {
        logic [15:0] sel;
        logic [31:0] base;
        logic [31:0] limit;
        logic [1:0]  rpl;
        logic [1:0]  dpl;
        logic        present;
        logic        user;
        logic [3:0]  typ;
        logic        big;
    } seg_cache_t;

    // Unpack a raw descriptor into cache form, scaling the limit by granularity.
    function automatic seg_cache_t decode_desc(input logic [63:0] d, input logic [15:0] sel);
        seg_cache_t c;
        logic [31:0] lim;
        lim       = {12'b0, d[51:48], d[15:0]};
        c.sel     = sel;
        c.base    = {d[63:56], d[39:16]};
        c.limit   = d[55] ? (lim << 12) : lim;
        c.rpl     = sel[1:0];
        c.dpl     = d[46:45];
        c.present = d[47];
        c.user    = d[44];
        c.typ     = d[43:40];
        c.big     = d[54];
        return c;
    endfunction

endpackage

// File: rtl/seg_precheck.sv
`timescale 1ns/1ps
// seg_precheck: decides, before any memory access, whether a load is a
// real-mode load, a table-limit or null-selector fault, a null data load,
// or needs a descriptor fetch; also forms the descriptor address.
// Assumes selector bit 2 picks the local table.
module seg_precheck #(
    parameter int AW = 32
) (
    input  logic                 prot_en,
    input  logic                 v86,
    input  logic [15:0]          sel,
    input  seg_pkg::seg_class_e  cls,
    input  logic [AW-1:0]        gdt_base,
    input  logic [15:0]          gdt_limit,
    input  logic [AW-1:0]        ldt_base,
    input  logic [31:0]          ldt_limit,
    output seg_pkg::path_e       path,
    output logic [15:0]          err_code,
    output logic [AW-1:0]        desc_addr
);
    import seg_pkg::*;

    logic [15:0] index;
    logic        use_local;
    logic        over_limit;
    logic        is_null;

    // Table selection and bounds test.
    always_comb begin
        index      = {sel[15:3], 3'b000};
        use_local  = sel[2];
        over_limit = use_local ? ({16'b0, index} > ldt_limit) : (index > gdt_limit);
        is_null    = (sel[15:3] == 13'd0);
        desc_addr  = (use_local ? ldt_base : gdt_base) + AW'(index);
    end

    // Path selection in check order: mode, limit, null.
    always_comb begin
        err_code = 16'd0;
        if (!prot_en || v86) begin
            path = PATH_REAL;
        end else if (over_limit) begin
            path     = PATH_FAULT;
            err_code = sel;
        end else if (is_null) begin
            path = (cls == CLS_CODE || cls == CLS_STACK) ? PATH_FAULT : PATH_NULL;
        end else begin
            path = PATH_FETCH;
        end
    end
endmodule

// File: rtl/seg_fetch.sv
`timescale 1ns/1ps
// seg_fetch: reads one 64-bit descriptor as 64/DW words, lowest word first.
// Assumes mem_valid both accepts the request and returns its data.
module seg_fetch #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] addr,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_valid,
    input  logic [DW-1:0] mem_data,
    output logic          fetch_done,
    output logic [63:0]   desc
);
    localparam int BEATS = 64 / DW;
    localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int STEP  = DW / 8;

    logic          active;
    logic [BW-1:0] beat;
    logic [AW-1:0] base_q;
    logic [DW-1:0] words [BEATS];

    // Beat sequencing and word capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active     <= 1'b0;
            beat       <= '0;
            base_q     <= '0;
            fetch_done <= 1'b0;
        end else begin
            fetch_done <= 1'b0;
            if (start && !active) begin
                active <= 1'b1;
                beat   <= '0;
                base_q <= addr;
            end else if (active && mem_valid) begin
                words[beat] <= mem_data;
                if (beat == BW'(BEATS - 1)) begin
                    active     <= 1'b0;
                    fetch_done <= 1'b1;
                end else begin
                    beat <= beat + 1'b1;
                end
            end
        end
    end

    assign mem_req  = active;
    assign mem_addr = base_q + (AW'(beat) * AW'(STEP));

    // Assemble the descriptor from its words.
    for (genvar g = 0; g < BEATS; g++) begin : g_join
        assign desc[g*DW +: DW] = words[g];
    end

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));
endmodule

// File: rtl/seg_rules.sv
`timescale 1ns/1ps
// seg_rules: judges a fetched descriptor for a stack, code or data load.
// Purely combinational; null selectors never reach it.
module seg_rules (
    input  seg_pkg::seg_class_e cls,
    input  logic [15:0]         sel,
    input  logic [1:0]          cpl,
    input  logic                user,
    input  logic                present,
    input  logic [1:0]          dpl,
    input  logic [3:1]          typ,
    output seg_pkg::flt_e       flt,
    output logic [15:0]         err_code
);
    import seg_pkg::*;

    logic [1:0] rpl;
    logic       exec;
    logic       conform;
    logic       wr;

    assign rpl     = sel[1:0];
    assign exec    = typ[3];
    assign conform = typ[2];
    assign wr      = typ[1];

    // Per-class rule chain; first violated rule wins.
    always_comb begin
        flt      = FLT_NONE;
        err_code = sel;
        case (cls)
            CLS_STACK: begin
                if (!user)                          flt = FLT_GP;
                else if (exec || !wr)               flt = FLT_GP;
                else if (rpl != cpl || rpl != dpl)  flt = FLT_GP;
                else if (!present)                  flt = FLT_STACK;
            end
            CLS_CODE: begin
                if (!user)                          flt = FLT_GP;
                else if (!present)                  flt = FLT_NP;
                else if (!exec)                     flt = FLT_GP;
                else if (conform) begin
                    if (dpl > cpl)                  flt = FLT_GP;
                end else if (rpl > cpl || cpl != dpl) flt = FLT_GP;
            end
            default: begin
                if (!user)                          flt = FLT_GP;
                else if (rpl > dpl || cpl > dpl)    flt = FLT_GP;
                else if (!present)                  flt = FLT_NP;
            end
        endcase
        if (flt == FLT_NONE) err_code = 16'd0;
    end
endmodule

// File: rtl/seg_cache.sv
`timescale 1ns/1ps
// seg_cache: hidden descriptor register with three write forms:
// real-mode (selector and base only), null (zeroed descriptor), full.
// Assumes at most one write enable per cycle.
module seg_cache (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we_real,
    input  logic                we_null,
    input  logic                we_full,
    input  logic [15:0]         sel,
    input  seg_pkg::seg_cache_t fresh,
    output seg_pkg::seg_cache_t q
);
    // Cache register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we_real) begin
            q.sel  <= sel;
            q.base <= {12'b0, sel, 4'b0000};
        end else if (we_null) begin
            q     <= '0;
            q.sel <= sel;
            q.rpl <= sel[1:0];
        end else if (we_full) begin
            q <= fresh;
        end
    end
endmodule

// File: rtl/seg_loader.sv
`timescale 1ns/1ps
// seg_loader: top of the segment register load path. Idle requests are
// resolved at once when no descriptor is needed; otherwise the descriptor
// is fetched, then judged one cycle later from registered data.
// Assumes requests are single-cycle and ignored while busy.
module seg_loader #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_req,
    input  logic [15:0]   ld_sel,
    input  logic [1:0]    ld_class,
    input  logic [1:0]    cur_cpl,
    input  logic          prot_en,
    input  logic          v86,
    input  logic [AW-1:0] gdt_base,
    input  logic [15:0]   gdt_limit,
    input  logic [AW-1:0] ldt_base,
    input  logic [31:0]   ldt_limit,
    output logic          mem_rd_req,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rd_valid,
    input  logic [DW-1:0] mem_rd_data,
    output logic          busy,
    output logic          done,
    output logic          flt_valid,
    output logic [1:0]    flt_class,
    output logic [15:0]   flt_code,
    output logic          cpl_wr,
    output logic [1:0]    cpl_new,
    output logic [15:0]   cache_sel,
    output logic [31:0]   cache_base,
    output logic [31:0]   cache_limit,
    output logic [1:0]    cache_rpl,
    output logic [1:0]    cache_dpl,
    output logic          cache_present,
    output logic          cache_user,
    output logic [3:0]    cache_type,
    output logic          cache_big
);
    import seg_pkg::*;

    typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_JUDGE} state_e;

    state_e     state;
    seg_class_e req_cls;
    seg_class_e cls_q;
    logic [15:0] sel_q;
    logic [1:0]  cpl_q;
    logic        real_q;

    path_e       path;
    logic [15:0] pre_code;
    logic [AW-1:0] desc_addr;
    logic        take;
    logic        fetch_go;
    logic        fetch_done;
    logic [63:0] desc;
    seg_cache_t  fresh;
    seg_cache_t  cache_q;
    flt_e        rule_flt;
    logic [15:0] rule_code;
    logic        we_real, we_null, we_full;

    assign req_cls  = (ld_class == 2'd1) ? CLS_CODE :
                      (ld_class == 2'd2) ? CLS_STACK : CLS_DATA;
    assign take     = (state == ST_IDLE) && ld_req;
    assign fetch_go = take && (path == PATH_FETCH);

    seg_precheck #(.AW(AW)) u_pre (
        .prot_en   (prot_en),
        .v86       (v86),
        .sel       (ld_sel),
        .cls       (req_cls),
        .gdt_base  (gdt_base),
        .gdt_limit (gdt_limit),
        .ldt_base  (ldt_base),
        .ldt_limit (ldt_limit),
        .path      (path),
        .err_code  (pre_code),
        .desc_addr (desc_addr)
    );

    seg_fetch #(.AW(AW), .DW(DW)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (fetch_go),
        .addr       (desc_addr),
        .mem_req    (mem_rd_req),
        .mem_addr   (mem_rd_addr),
        .mem_valid  (mem_rd_valid),
        .mem_data   (mem_rd_data),
        .fetch_done (fetch_done),
        .desc       (desc)
    );

    assign fresh = decode_desc(desc, sel_q);

    seg_rules u_rules (
        .cls      (cls_q),
        .sel      (sel_q),
        .cpl      (cpl_q),
        .user     (fresh.user),
        .present  (fresh.present),
        .dpl      (fresh.dpl),
        .typ      (fresh.typ[3:1]),
        .flt      (rule_flt),
        .err_code (rule_code)
    );

    // Cache write selection.
    always_comb begin
        we_real = take && (path == PATH_REAL);
        we_null = take && (path == PATH_NULL);
        we_full = (state == ST_JUDGE) && (rule_flt == FLT_NONE);
    end

    seg_cache u_cache (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_real (we_real),
        .we_null (we_null),
        .we_full (we_full),
        .sel     ((state == ST_JUDGE) ? sel_q : ld_sel),
        .fresh   (fresh),
        .q       (cache_q)
    );

    // Load sequencing and outcome strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cls_q     <= CLS_DATA;
            sel_q     <= '0;
            cpl_q     <= '0;
            real_q    <= 1'b0;
            done      <= 1'b0;
            flt_valid <= 1'b0;
            flt_class <= '0;
            flt_code  <= '0;
            cpl_wr    <= 1'b0;
            cpl_new   <= '0;
        end else begin
            done      <= 1'b0;
            flt_valid <= 1'b0;
            cpl_wr    <= 1'b0;
            case (state)
                ST_IDLE: if (ld_req) begin
                    sel_q  <= ld_sel;
                    cls_q  <= req_cls;
                    cpl_q  <= cur_cpl;
                    real_q <= (path == PATH_REAL);
                    case (path)
                        PATH_REAL, PATH_NULL: done <= 1'b1;
                        PATH_FAULT: begin
                            flt_valid <= 1'b1;
                            flt_class <= FLT_GP;
                            flt_code  <= pre_code;
                        end
                        default: state <= ST_FETCH;
                    endcase
                end
                ST_FETCH: if (fetch_done) state <= ST_JUDGE;
                default: begin
                    state <= ST_IDLE;
                    if (rule_flt != FLT_NONE) begin
                        flt_valid <= 1'b1;
                        flt_class <= rule_flt;
                        flt_code  <= rule_code;
                    end else begin
                        done <= 1'b1;
                        if (cls_q == CLS_CODE) begin
                            cpl_wr  <= 1'b1;
                            cpl_new <= sel_q[1:0];
                        end
                    end
                end
            endcase
        end
    end

    assign busy          = (state != ST_IDLE);
    assign cache_sel     = cache_q.sel;
    assign cache_base    = cache_q.base;
    assign cache_limit   = cache_q.limit;
    assign cache_rpl     = cache_q.rpl;
    assign cache_dpl     = cache_q.dpl;
    assign cache_present = cache_q.present;
    assign cache_user    = cache_q.user;
    assign cache_type    = cache_q.typ;
    assign cache_big     = cache_q.big;

    assert_single_outcome_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && flt_valid));
    assert_fault_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |=> !flt_valid);
    assert_cache_kept_R12: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> ($stable(cache_sel) && $stable(cache_base) && $stable(cache_limit)));
    assert_cpl_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_wr |-> done);
    assert_real_base_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && real_q) |-> (cache_base == {12'b0, cache_sel, 4'b0000}));
    assert_idle_no_read_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_rd_req);
endmodule

// File: tb/seg_loader_test.sv
`timescale 1ns/1ps
module seg_loader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_req = 1'b0;
    logic [15:0] ld_sel = '0;
    logic [1:0]  ld_class = '0;
    logic [1:0]  cur_cpl = '0;
    logic        prot_en = 1'b0;
    logic        v86 = 1'b0;
    logic [31:0] gdt_base = 32'h100;
    logic [15:0] gdt_limit = 16'h003F;
    logic [31:0] ldt_base = 32'h200;
    logic [31:0] ldt_limit = 32'h1F;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        busy, done, flt_valid, cpl_wr, cache_present, cache_user, cache_big;
    logic [1:0]  flt_class, cpl_new, cache_rpl, cache_dpl;
    logic [15:0] flt_code, cache_sel;
    logic [31:0] cache_base, cache_limit;
    logic [3:0]  cache_type;

    always #2.5 clk = ~clk;

    seg_loader uut (.*);

    logic [31:0] mem [0:255];
    int mem_lat = 0;
    int rd_count = 0;
    int nchk = 0;
    int nerr = 0;

    // Outcome of the last load.
    logic        o_done, o_flt, o_cplwr, o_clear;
    logic [1:0]  o_cls, o_cplnew;
    logic [15:0] o_code;
    int          o_reads;

    // Memory model: answers held requests after mem_lat idle cycles.
    initial begin
        int cnt;
        cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_rd_req && !mem_rd_valid && cnt >= mem_lat) begin
                mem_rd_valid = 1'b1;
                mem_rd_data  = mem[mem_rd_addr[9:2]];
                rd_count++;
                cnt = 0;
            end else begin
                mem_rd_valid = 1'b0;
                cnt = mem_rd_req ? cnt + 1 : 0;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    function automatic logic [63:0] mk(input logic [31:0] b, input logic [19:0] l,
                                        input logic g, input logic big, input logic p,
                                        input logic [1:0] dpl, input logic s,
                                        input logic [3:0] typ);
        return {b[31:24], g, big, 2'b00, l[19:16], p, dpl, s, typ, b[23:0], l[15:0]};
    endfunction

    task automatic put(input int byte_addr, input logic [63:0] d);
        mem[byte_addr >> 2]       = d[31:0];
        mem[(byte_addr >> 2) + 1] = d[63:32];
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [15:0] sel, input logic [1:0] cls, input logic [1:0] cpl,
                        input logic pe, input logic vm);
        int n, r0;
        @(negedge clk);
        ld_sel = sel; ld_class = cls; cur_cpl = cpl; prot_en = pe; v86 = vm;
        ld_req = 1'b1; r0 = rd_count;
        @(negedge clk);
        ld_req = 1'b0;
        n = 0;
        while (!(done || flt_valid) && n < 60) begin
            @(negedge clk);
            n++;
        end
        if (n >= 60) begin nerr++; $display("FAIL no outcome for selector %h", sel); end
        o_done = done; o_flt = flt_valid; o_cls = flt_class; o_code = flt_code;
        o_cplwr = cpl_wr; o_cplnew = cpl_new;
        @(negedge clk);
        o_clear = !done && !flt_valid;
        o_reads = rd_count - r0;
    endtask

    // Expect a fault with class and code; cache selector unchanged.
    task automatic expect_fault(input string tag, input logic [15:0] sel, input logic [1:0] cls,
                                input logic [1:0] cpl, input logic [1:0] fc, input logic [15:0] code);
        logic [15:0] prev;
        prev = cache_sel;
        load(sel, cls, cpl, 1'b1, 1'b0);
        chk({tag, " fault"}, {31'b0, o_flt}, 32'd1);
        chk({tag, " class"}, {30'b0, o_cls}, {30'b0, fc});
        chk({tag, " code"}, {16'b0, o_code}, {16'b0, code});
        chk({tag, " R12 cache kept"}, {16'b0, cache_sel}, {16'b0, prev});
    endtask

    task automatic t_reset;
        chk("R12 reset done", {31'b0, done}, 0);
        chk("R12 reset flt", {31'b0, flt_valid}, 0);
        chk("R13 reset busy", {31'b0, busy}, 0);
        chk("R1 reset base", cache_base, 0);
    endtask

    task automatic t_data_ok;
        load(16'h000B, 2'd0, 2'd3, 1'b1, 1'b0);
        chk("R9 data pass", {31'b0, o_done}, 1);
        chk("R2 two reads", o_reads, 2);
        chk("R10 base", cache_base, 32'hAB123456);
        chk("R11 limit scaled", cache_limit, 32'h00012000);
        chk("R10 attrs", {20'b0, cache_dpl, cache_rpl, cache_present, cache_user, cache_type, cache_big},
            {20'b0, 2'd3, 2'd3, 1'b1, 1'b1, 4'b0010, 1'b1});
        chk("R7 data no cpl", {31'b0, o_cplwr}, 0);
        chk("R12 done pulse", {31'b0, o_clear}, 1);
        load(16'h0010, 2'd0, 2'd0, 1'b1, 1'b0);
        chk("R11 limit unscaled", cache_limit, 32'h000ABCDE);
        chk("R10 base2", cache_base, 32'h00C0FFEE);
    endtask

    task automatic t_real;
        load(16'h1234, 2'd0, 2'd0, 1'b0, 1'b0);
        chk("R1 real done", {31'b0, o_done}, 1);
        chk("R1 real base", cache_base, 32'h00012340);
        chk("R1 real limit kept", cache_limit, 32'h000ABCDE);
        chk("R1 no read", o_reads, 0);
        load(16'hF00F, 2'd1, 2'd0, 1'b1, 1'b1);
        chk("R1 v86 base", cache_base, 32'h000F00F0);
        chk("R1 v86 sel", {16'b0, cache_sel}, 32'hF00F);
        chk("R7 v86 no cpl", {31'b0, o_cplwr}, 0);
    endtask

    task automatic t_limit;
        expect_fault("R3 gdt", 16'h0040, 2'd0, 2'd0, 2'd1, 16'h0040);
        chk("R3 no read", o_reads, 0);
        chk("R12 fault pulse", {31'b0, o_clear}, 1);
        expect_fault("R3 ldt", 16'h0024, 2'd0, 2'd0, 2'd1, 16'h0024);
    endtask

    task automatic t_null_data;
        load(16'h0003, 2'd0, 2'd3, 1'b1, 1'b0);
        chk("R8 null done", {31'b0, o_done}, 1);
        chk("R8 null sel", {16'b0, cache_sel}, 32'h0003);
        chk("R8 null zero", cache_base | cache_limit, 0);
        chk("R8 null fields", {22'b0, cache_rpl, cache_dpl, cache_present, cache_user, cache_type},
            {22'b0, 2'd3, 8'b0});
        chk("R8 null no read", o_reads, 0);
    endtask

    task automatic t_data_faults;
        expect_fault("R9 rpl>dpl", 16'h0013, 2'd0, 2'd0, 2'd1, 16'h0013);
        expect_fault("R9 cpl>dpl", 16'h0010, 2'd0, 2'd3, 2'd1, 16'h0010);
        expect_fault("R9 not present", 16'h001B, 2'd0, 2'd3, 2'd2, 16'h001B);
        expect_fault("R9 system", 16'h0020, 2'd0, 2'd0, 2'd1, 16'h0020);
    endtask

    task automatic t_stack;
        expect_fault("R4 null", 16'h0000, 2'd2, 2'd0, 2'd1, 16'h0000);
        expect_fault("R4 rpl!=dpl", 16'h0008, 2'd2, 2'd0, 2'd1, 16'h0008);
        expect_fault("R4 exec", 16'h0028, 2'd2, 2'd0, 2'd1, 16'h0028);
        expect_fault("R4 system", 16'h0020, 2'd2, 2'd0, 2'd1, 16'h0020);
        expect_fault("R4 not present", 16'h0038, 2'd2, 2'd0, 2'd3, 16'h0038);
        load(16'h000C, 2'd2, 2'd0, 1'b1, 1'b0);
        chk("R4 stack pass", {31'b0, o_done}, 1);
        chk("R2 local table base", cache_base, 32'h00050000);
    endtask

    task automatic t_code;
        expect_fault("R5 null", 16'h0000, 2'd1, 2'd0, 2'd1, 16'h0000);
        expect_fault("R5 np before exec", 16'h0014, 2'd1, 2'd0, 2'd2, 16'h0014);
        expect_fault("R5 not exec", 16'h0010, 2'd1, 2'd0, 2'd1, 16'h0010);
        expect_fault("R6 conforming dpl>cpl", 16'h001C, 2'd1, 2'd0, 2'd1, 16'h001C);
        expect_fault("R6 cpl!=dpl", 16'h0028, 2'd1, 2'd3, 2'd1, 16'h0028);
        expect_fault("R6 rpl>cpl", 16'h002B, 2'd1, 2'd0, 2'd1, 16'h002B);
        load(16'h0031, 2'd1, 2'd2, 1'b1, 1'b0);
        chk("R6 conforming pass", {31'b0, o_done}, 1);
        chk("R7 cpl_wr", {31'b0, o_cplwr}, 1);
        chk("R7 cpl_new", {30'b0, o_cplnew}, 32'd1);
        load(16'h0028, 2'd1, 2'd0, 1'b1, 1'b0);
        chk("R7 cpl_new zero", {30'b0, o_cplnew}, 32'd0);
        chk("R7 cpl_wr2", {31'b0, o_cplwr}, 1);
    endtask

    task automatic t_busy;
        int n;
        mem_lat = 4;
        @(negedge clk);
        ld_sel = 16'h0031; ld_class = 2'd1; cur_cpl = 2'd2; prot_en = 1'b1; v86 = 1'b0;
        ld_req = 1'b1;
        @(negedge clk);
        ld_req = 1'b0;
        @(negedge clk);
        chk("R13 busy during fetch", {31'b0, busy}, 1);
        ld_sel = 16'h5555; ld_class = 2'd0; prot_en = 1'b0; ld_req = 1'b1;
        @(negedge clk);
        ld_req = 1'b0;
        n = 0;
        while (!done && n < 60) begin @(negedge clk); n++; end
        chk("R13 first load kept", {16'b0, cache_sel}, 32'h0031);
        repeat (6) begin
            @(negedge clk);
            chk("R13 no extra done", {31'b0, done}, 0);
        end
        chk("R13 ignored selector", {16'b0, cache_sel}, 32'h0031);
        mem_lat = 0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        put(32'h108, mk(32'hAB123456, 20'h00012, 1, 1, 1, 2'd3, 1, 4'b0010));
        put(32'h110, mk(32'h00C0FFEE, 20'hABCDE, 0, 0, 1, 2'd0, 1, 4'b0010));
        put(32'h118, mk(32'h00001000, 20'h00FFF, 0, 0, 0, 2'd3, 1, 4'b0010));
        put(32'h120, mk(32'h00002000, 20'h00FFF, 0, 0, 1, 2'd0, 0, 4'b0010));
        put(32'h128, mk(32'h00003000, 20'h0FFFF, 0, 1, 1, 2'd0, 1, 4'b1010));
        put(32'h130, mk(32'h00004000, 20'h0FFFF, 0, 1, 1, 2'd1, 1, 4'b1110));
        put(32'h138, mk(32'h00005000, 20'h0FFFF, 0, 0, 0, 2'd0, 1, 4'b0010));
        put(32'h208, mk(32'h00050000, 20'h0FFFF, 0, 0, 1, 2'd0, 1, 4'b0010));
        put(32'h210, mk(32'h00060000, 20'h0FFFF, 0, 0, 0, 2'd0, 1, 4'b0010));
        put(32'h218, mk(32'h00070000, 20'h0FFFF, 0, 0, 1, 2'd3, 1, 4'b1110));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_data_ok();
        t_real();
        t_limit();
        t_null_data();
        t_data_faults();
        t_stack();
        t_code();
        t_busy();
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule